// File: doc/BRIEF.md
# Sleep and Standby Power Controller

This block controls the low-power modes of a small microcontroller core. It holds an 8-bit control register that software reaches through a plain write/read port. Two bits in it matter: one picks between a light sleep mode and a deep standby mode, and the other decides whether the I/O ports float during standby. When the CPU reports that it has executed its sleep instruction, the controller enters the selected mode. It then drives a CPU halt, a peripheral clock enable, a main clock enable, a one-cycle peripheral reset strobe and a port high-impedance enable.

In sleep mode only the CPU stops, and any interrupt request, an NMI or a DMA address error brings it back. In standby mode the clocks stop as well, and only an NMI wakes the core. After that wake the controller turns the clocks back on and holds the CPU for an oscillator-settling interval before it releases it. Both a power-on reset and a manual reset return the controller to the running state at once. Only the power-on reset clears the control register.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: On power-on reset (`rst` high at a clock edge) the mode code is 00, `cpu_halt` is 0, both clock enables are 1, `per_rst_stb` and `port_hiz` are 0, and the control register reads 0x00.
- R2: A write stores bit 7 (standby select) and bit 6 (port float) of `reg_wdata`. `reg_rdata` shows those two bits in the same positions and reads zero in bits 5..0.
- R3: In run mode, a `sleep_req` pulse with bit 7 clear and no pending sleep wake source enters sleep after one edge. The mode code is then 01, `cpu_halt` is 1, both clock enables stay 1 and no peripheral reset strobe is issued.
- R4: In run mode, a `sleep_req` pulse with bit 7 set and no pending NMI enters standby after one edge. The mode code is then 10, `cpu_halt` is 1 and both clock enables are 0. `per_rst_stb` is high for exactly the first standby cycle.
- R5: In sleep, any one of `irq_req`, `nmi` or `dma_addr_err` returns the controller to run mode (code 00, halt released) after one edge.
- R6: In standby, `irq_req` and `dma_addr_err` have no effect: the mode code stays 10 and the clocks stay off.
- R7: In standby, `nmi` enters the settling state (code 11) with `cpu_halt` 1 and both clock enables 1. The state lasts N cycles and is then followed by run. N is `settle_cycles` sampled at the NMI and clamped to the range 16..4096.
- R8: During standby and settling, `port_hiz` equals bit 6 of the control register. In run and sleep it is 0.
- R9: `man_rst` in any mode returns to run mode after one edge and keeps the control register. `rst` in any mode returns to run mode and clears the register.
- R10: A `sleep_req` pulse that coincides with a wake event for the selected mode is ignored and the controller stays in run mode. The wake events are an interrupt, an NMI or a DMA address error for sleep, and an NMI for standby.
- R11: `mode` encodes the state as 00 run, 01 sleep, 10 standby and 11 settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_req | input | 1 | One-cycle pulse: CPU executed the sleep instruction |
| irq_req | input | 1 | Any maskable interrupt request |
| nmi | input | 1 | Non-maskable interrupt |
| dma_addr_err | input | 1 | DMA address error event |
| settle_cycles | input | 13 | Oscillator settling length, clamped to 16..4096 |
| mode | output | 2 | Current mode code |
| cpu_halt | output | 1 | Halt the CPU core |
| per_clk_en | output | 1 | Peripheral clock enable |
| main_clk_en | output | 1 | Main clock enable |
| per_rst_stb | output | 1 | One-cycle peripheral reset on standby entry |
| port_hiz | output | 1 | Float the I/O ports |

## Verification
The assertions check the mode transitions on every cycle. Standby must hold against interrupts and DMA errors, sleep must leave on any of its wake sources, and a manual reset must always land in run mode. A sleep request that meets a pending wake must leave the core running. The reset strobe may appear only on a run-to-standby step, and each settle load must lie inside the clamp range. Only the bench scenarios can show that the settling interval has exactly the clamped length at both ends of the range. They also show that the register keeps its value across a manual reset but not across a power-on reset, and that the port float follows bit 6 through standby and settling.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'b00,
    PM_SLEEP  = 2'b01,
    PM_STBY   = 2'b10,
    PM_SETTLE = 2'b11
  } pm_mode_e;

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg #(
  parameter int REG_W   = 8,
  parameter int SBY_POS = 7,
  parameter int HIZ_POS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             sby_sel_o,
  output logic             hiz_sel_o
);

  localparam logic [REG_W-1:0] KEEP_MASK =
    (REG_W'(1) << SBY_POS) | (REG_W'(1) << HIZ_POS);

  logic sby_q;
  logic hiz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sby_q <= 1'b0;
      hiz_q <= 1'b0;
    end else if (we_i) begin
      sby_q <= wdata_i[SBY_POS];
      hiz_q <= wdata_i[HIZ_POS];
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[SBY_POS] = sby_q;
    rdata_o[HIZ_POS] = hiz_q;
  end

  assign sby_sel_o = sby_q;
  assign hiz_sel_o = hiz_q;

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata_o & ~KEEP_MASK) == '0);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (rdata_o == ($past(wdata_i) & KEEP_MASK)));

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int MIN_SETTLE = 16,
  parameter int MAX_SETTLE = 4096,
  parameter int CNT_W      = $clog2(MAX_SETTLE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_SETTLE);
  localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_SETTLE);

  logic [CNT_W-1:0] len_clamped;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (len_i < LO)      len_clamped = LO;
    else if (len_i > HI) len_clamped = HI;
    else                 len_clamped = len_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load_i)         cnt_q <= len_clamped - CNT_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);

  // R7
  settle_range_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q >= LO - CNT_W'(1)) && (cnt_q <= HI - CNT_W'(1)));

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       man_rst_i,
  input  logic       sleep_i,
  input  logic       irq_i,
  input  logic       nmi_i,
  input  logic       dma_err_i,
  input  logic       sby_sel_i,
  input  logic       hiz_sel_i,
  input  logic       settle_done_i,
  output logic       settle_load_o,
  output logic [1:0] mode_o,
  output logic       cpu_halt_o,
  output logic       per_clk_en_o,
  output logic       main_clk_en_o,
  output logic       per_rst_stb_o,
  output logic       port_hiz_o
);

  pm_mode_e state_q, state_d;
  logic     sleep_wake;
  logic     stby_wake;

  assign sleep_wake = irq_i | nmi_i | dma_err_i;
  assign stby_wake  = nmi_i;

  always_comb begin
    state_d       = state_q;
    settle_load_o = 1'b0;
    if (man_rst_i) begin
      state_d = PM_RUN;
    end else begin
      case (state_q)
        PM_RUN: begin
          if (sleep_i) begin
            if (sby_sel_i) begin
              if (!stby_wake) state_d = PM_STBY;
            end else if (!sleep_wake) begin
              state_d = PM_SLEEP;
            end
          end
        end
        PM_SLEEP:  if (sleep_wake) state_d = PM_RUN;
        PM_STBY: begin
          if (stby_wake) begin
            state_d       = PM_SETTLE;
            settle_load_o = 1'b1;
          end
        end
        PM_SETTLE: if (settle_done_i) state_d = PM_RUN;
        default:   state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= PM_RUN;
      cpu_halt_o    <= 1'b0;
      per_clk_en_o  <= 1'b1;
      main_clk_en_o <= 1'b1;
      per_rst_stb_o <= 1'b0;
      port_hiz_o    <= 1'b0;
    end else begin
      state_q       <= state_d;
      cpu_halt_o    <= (state_d != PM_RUN);
      per_clk_en_o  <= (state_d != PM_STBY);
      main_clk_en_o <= (state_d != PM_STBY);
      per_rst_stb_o <= (state_q == PM_RUN) && (state_d == PM_STBY);
      port_hiz_o    <= hiz_sel_i &&
                       ((state_d == PM_STBY) || (state_d == PM_SETTLE));
    end
  end

  assign mode_o = state_q;

  // R6
  stby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_STBY && !nmi_i && !man_rst_i) |=>
      (state_q == PM_STBY) && !main_clk_en_o && !per_clk_en_o);

  // R5
  sleep_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_SLEEP && sleep_wake && !man_rst_i) |=>
      (state_q == PM_RUN) && !cpu_halt_o);

  // R9
  man_rst_run_chk: assert property (@(posedge clk) disable iff (rst)
    man_rst_i |=> (mode_o == 2'b00) && !cpu_halt_o && main_clk_en_o);

  // R4
  stb_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    per_rst_stb_o |-> (state_q == PM_STBY) && ($past(state_q) == PM_RUN));

  // R10
  pending_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RUN && sleep_i && !man_rst_i &&
     (sby_sel_i ? stby_wake : sleep_wake)) |=> (state_q == PM_RUN));

  // R3
  sleep_clocks_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RUN && sleep_i && !sby_sel_i && !sleep_wake && !man_rst_i) |=>
      cpu_halt_o && main_clk_en_o && per_clk_en_o && !per_rst_stb_o);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int REG_W      = 8,
  parameter int MIN_SETTLE = 16,
  parameter int MAX_SETTLE = 4096,
  parameter int CNT_W      = $clog2(MAX_SETTLE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             man_rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sleep_req,
  input  logic             irq_req,
  input  logic             nmi,
  input  logic             dma_addr_err,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic [1:0]       mode,
  output logic             cpu_halt,
  output logic             per_clk_en,
  output logic             main_clk_en,
  output logic             per_rst_stb,
  output logic             port_hiz
);

  logic sby_sel;
  logic hiz_sel;
  logic settle_load;
  logic settle_done;

  pmc_ctrl_reg #(
    .REG_W  (REG_W),
    .SBY_POS(REG_W - 1),
    .HIZ_POS(REG_W - 2)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .we_i     (reg_we),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .sby_sel_o(sby_sel),
    .hiz_sel_o(hiz_sel)
  );

  pmc_settle_timer #(
    .MIN_SETTLE(MIN_SETTLE),
    .MAX_SETTLE(MAX_SETTLE),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load_i(settle_load),
    .len_i (settle_cycles),
    .done_o(settle_done)
  );

  pmc_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .man_rst_i    (man_rst),
    .sleep_i      (sleep_req),
    .irq_i        (irq_req),
    .nmi_i        (nmi),
    .dma_err_i    (dma_addr_err),
    .sby_sel_i    (sby_sel),
    .hiz_sel_i    (hiz_sel),
    .settle_done_i(settle_done),
    .settle_load_o(settle_load),
    .mode_o       (mode),
    .cpu_halt_o   (cpu_halt),
    .per_clk_en_o (per_clk_en),
    .main_clk_en_o(main_clk_en),
    .per_rst_stb_o(per_rst_stb),
    .port_hiz_o   (port_hiz)
  );

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;

  logic        clk = 1'b0;
  logic        rst, man_rst, reg_we, sleep_req, irq_req, nmi, dma_addr_err;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [12:0] settle_cycles;
  logic [1:0]  mode;
  logic        cpu_halt, per_clk_en, main_clk_en, per_rst_stb, port_hiz;

  always #10 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rst(rst), .man_rst(man_rst), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .irq_req(irq_req), .nmi(nmi), .dma_addr_err(dma_addr_err),
    .settle_cycles(settle_cycles), .mode(mode), .cpu_halt(cpu_halt),
    .per_clk_en(per_clk_en), .main_clk_en(main_clk_en),
    .per_rst_stb(per_rst_stb), .port_hiz(port_hiz)
  );

  typedef struct {
    string      req;
    logic [1:0] md;
    logic       stb;
    logic       hiz;
    logic [7:0] rd;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  logic m_sby  = 1'b0;
  logic m_hiz  = 1'b0;
  bit   finished = 0;

  localparam logic [1:0] RUN = 2'b00, SLP = 2'b01, SBY = 2'b10, SET = 2'b11;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver: queue the expectation for the edge that follows, then release pulses
  task automatic tick(input logic [1:0] em, input logic es, input string req);
    exp_t e;
    e.req = req;
    e.md  = em;
    e.stb = es;
    e.hiz = m_hiz && ((em == SBY) || (em == SET));
    e.rd  = {m_sby, m_hiz, 6'b0};
    q.push_back(e);
    @(negedge clk);
    rst = 0; man_rst = 0; reg_we = 0; sleep_req = 0;
    irq_req = 0; nmi = 0; dma_addr_err = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1; reg_wdata = v;
    m_sby = v[7]; m_hiz = v[6];
    tick(RUN, 0, "R2");
  endtask

  // monitor: compare after each rising edge
  always begin
    @(posedge clk);
    #4;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "mode", mode, e.md);
      chk(e.req, "cpu_halt", cpu_halt, e.md != RUN);
      chk(e.req, "per_clk_en", per_clk_en, e.md != SBY);
      chk(e.req, "main_clk_en", main_clk_en, e.md != SBY);
      chk(e.req, "per_rst_stb", per_rst_stb, e.stb);
      chk(e.req, "port_hiz", port_hiz, e.hiz);
      chk(e.req, "reg_rdata", reg_rdata, e.rd);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; man_rst = 0; reg_we = 0; reg_wdata = 0; sleep_req = 0;
    irq_req = 0; nmi = 0; dma_addr_err = 0; settle_cycles = 13'd16;
    m_sby = 0; m_hiz = 0;
    // R1 reset state
    tick(RUN, 0, "R1");
    tick(RUN, 0, "R1");

    // R2 register bits
    wr(8'hFF);
    wr(8'h3F);

    // R3 / R11 sleep entry and idle hold
    sleep_req = 1; tick(SLP, 0, "R3");
    tick(SLP, 0, "R11");
    // R5 wake by interrupt, DMA error, NMI
    irq_req = 1; tick(RUN, 0, "R5");
    sleep_req = 1; tick(SLP, 0, "R3");
    dma_addr_err = 1; tick(RUN, 0, "R5");
    sleep_req = 1; tick(SLP, 0, "R3");
    nmi = 1; tick(RUN, 0, "R5");

    // R10 sleep request with pending interrupt is ignored
    sleep_req = 1; irq_req = 1; tick(RUN, 0, "R10");
    tick(RUN, 0, "R10");

    // R4 standby entry without float
    wr(8'h80);
    sleep_req = 1; nmi = 1; tick(RUN, 0, "R10");
    sleep_req = 1; irq_req = 1; tick(SBY, 1, "R4");
    tick(SBY, 0, "R4");
    // R6 interrupt and DMA error ignored
    irq_req = 1; tick(SBY, 0, "R6");
    dma_addr_err = 1; tick(SBY, 0, "R6");
    irq_req = 1; dma_addr_err = 1; tick(SBY, 0, "R6");

    // R7 settle below minimum clamps to 16
    settle_cycles = 13'd5;
    nmi = 1; tick(SET, 0, "R7");
    for (int i = 0; i < 15; i++) tick(SET, 0, "R7");
    tick(RUN, 0, "R7");

    // R8 float during standby and settling, 100 cycles
    wr(8'hC0);
    sleep_req = 1; tick(SBY, 1, "R8");
    settle_cycles = 13'd100;
    nmi = 1; tick(SET, 0, "R8");
    for (int i = 0; i < 99; i++) tick(SET, 0, "R7");
    tick(RUN, 0, "R8");

    // R7 settle above maximum clamps to 4096
    sleep_req = 1; tick(SBY, 1, "R4");
    settle_cycles = 13'd8000;
    nmi = 1; tick(SET, 0, "R7");
    for (int i = 0; i < 4095; i++) tick(SET, 0, "R7");
    tick(RUN, 0, "R7");

    // R9 manual reset from standby, sleep, settling keeps register
    sleep_req = 1; tick(SBY, 1, "R4");
    man_rst = 1; tick(RUN, 0, "R9");
    wr(8'h40);
    sleep_req = 1; tick(SLP, 0, "R3");
    man_rst = 1; tick(RUN, 0, "R9");
    wr(8'hC0);
    sleep_req = 1; tick(SBY, 1, "R4");
    nmi = 1; tick(SET, 0, "R7");
    tick(SET, 0, "R7");
    man_rst = 1; tick(RUN, 0, "R9");

    // R9 power-on reset from standby clears register
    sleep_req = 1; tick(SBY, 1, "R4");
    rst = 1; m_sby = 0; m_hiz = 0; tick(RUN, 0, "R9");
    // after clear, a sleep request gives sleep, not standby
    sleep_req = 1; tick(SLP, 0, "R9");
    irq_req = 1; tick(RUN, 0, "R5");

    @(negedge clk);
    finish_run();
  end

endmodule